// File: doc/BRIEF.md
# Dual-Lane Multicast Route Splitter for a 2D Mesh

This unit decides where a multicast packet goes next inside one router of a two-dimensional mesh. Each packet carries a destination bitmask with one bit per endpoint in the mesh. Every node has two endpoints, and each endpoint has its own local ejection port. At each hop the unit splits the mask into six disjoint subsets: east, west, north, south, local port 0 and local port 1. Each subset goes to one output, so the multicast tree branches where the destinations diverge.

Two lanes exist, and they use opposite dimension orders. Lane 0 resolves the column first (XY) and then the row. Lane 1 resolves the row first (YX) and then the column. A single fixed order loads the X and Y channels unevenly, and the imbalance grows with mesh size. For that reason the lane is picked when a packet is injected at its source, and the picks alternate between the two orders. A packet that is only passing through keeps the lane it carries. The result is registered and appears one cycle after the input.

Top module: `mc_route_unit`

## Requirements
- R1: Outputs appear one clock after the input. When the input was not valid, `out_valid` is 0, `out_lane` is 0 and all six masks are zero, whatever the destination input held.
- R2: On lane 0 (XY), a destination endpoint in a column east of the node (larger x) goes to east, and one in a column with smaller x goes to west. In the node's own column, a larger y goes north and a smaller y goes south.
- R3: On lane 1 (YX), a larger row y goes north and a smaller row y goes south. In the node's own row, a larger x goes east and a smaller x goes west.
- R4: Destination bit index is `2*(y*W + x) + e`. An endpoint of the node itself with e=0 goes to `out_loc0`, and one with e=1 goes to `out_loc1`.
- R5: When the output is valid, the six masks are pairwise disjoint and their union equals the destination mask of the input.
- R6: For a valid packet with `in_inject`=0, `out_lane` equals `in_lane`. The lane is never altered in transit.
- R7: For a valid packet with `in_inject`=1, `in_lane` is ignored. The lane is taken from a picker that starts at 0 after reset and toggles after each valid injected packet. Other cycles do not move the picker.
- R8: While `rst_n` is low, all outputs are zero and the picker returns to lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A packet head is present |
| in_inject | input | 1 | Packet enters the network at this node |
| in_lane | input | 1 | Carried lane, 0 = XY, 1 = YX |
| in_dest | input | 2*W*H | Destination endpoint mask |
| here_x | input | clog2(W) | Column of this node |
| here_y | input | clog2(H) | Row of this node |
| out_valid | output | 1 | Split result valid |
| out_lane | output | 1 | Lane used for the split |
| out_east | output | 2*W*H | Subset sent east |
| out_west | output | 2*W*H | Subset sent west |
| out_north | output | 2*W*H | Subset sent north |
| out_south | output | 2*W*H | Subset sent south |
| out_loc0 | output | 2*W*H | Subset ejected to local endpoint 0 |
| out_loc1 | output | 2*W*H | Subset ejected to local endpoint 1 |

## Verification
The lane pick for an injected packet and the split that depends on that pick happen in the same cycle. A wrong pick therefore shows up as a changed branching pattern, not only as a wrong lane bit. The bench provokes this with runs of back-to-back injections that carry an `in_lane` opposite to the expected pick, mixed with transit packets and idle cycles. It judges every output mask against a reference split computed from a separately tracked alternation. Local ejection and four-way forwarding also coincide when all-ones masks are used at corner and interior nodes, and the union/disjoint checks judge those cases.

// File: rtl/mc_pkg.sv
package mc_pkg;
    typedef enum logic {
        LANE_XY = 1'b0,
        LANE_YX = 1'b1
    } lane_e;

    localparam int ENDPOINTS_PER_NODE = 2;
endpackage

// File: rtl/mc_lane_pick.sv
module mc_lane_pick
    import mc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fire,
    output lane_e pick
);
    typedef struct packed {
        lane_e nxt;
    } pick_st_t;

    pick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.nxt = (st_q.nxt == LANE_XY) ? LANE_YX : LANE_XY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{nxt: LANE_XY};
        else        st_q <= st_d;
    end

    assign pick = st_q.nxt;

    // R7
    lane_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> pick != $past(pick));
    // R7
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(pick));
endmodule

// File: rtl/mc_port_split.sv
module mc_port_split
    import mc_pkg::*;
#(
    parameter int W  = 4,
    parameter int H  = 4,
    localparam int N  = W * H * ENDPOINTS_PER_NODE,
    localparam int XW = (W > 1) ? $clog2(W) : 1,
    localparam int YW = (H > 1) ? $clog2(H) : 1
) (
    input  logic [N-1:0]  dest,
    input  lane_e         lane,
    input  logic [XW-1:0] my_x,
    input  logic [YW-1:0] my_y,
    output logic [N-1:0]  to_e,
    output logic [N-1:0]  to_w,
    output logic [N-1:0]  to_n,
    output logic [N-1:0]  to_s,
    output logic [N-1:0]  to_l0,
    output logic [N-1:0]  to_l1
);
    for (genvar gy = 0; gy < H; gy++) begin : g_row
        for (genvar gx = 0; gx < W; gx++) begin : g_col
            localparam logic [XW-1:0] CX = XW'(gx);
            localparam logic [YW-1:0] CY = YW'(gy);
            logic col_gt, col_lt, col_eq, row_gt, row_lt, row_eq, yx;
            assign col_gt = CX > my_x;
            assign col_lt = CX < my_x;
            assign col_eq = CX == my_x;
            assign row_gt = CY > my_y;
            assign row_lt = CY < my_y;
            assign row_eq = CY == my_y;
            assign yx     = (lane == LANE_YX);
            for (genvar ge = 0; ge < ENDPOINTS_PER_NODE; ge++) begin : g_ep
                localparam int IDX = (gy * W + gx) * ENDPOINTS_PER_NODE + ge;
                assign to_e[IDX] = dest[IDX] & (yx ? (row_eq & col_gt) : col_gt);
                assign to_w[IDX] = dest[IDX] & (yx ? (row_eq & col_lt) : col_lt);
                assign to_n[IDX] = dest[IDX] & (yx ? row_gt : (col_eq & row_gt));
                assign to_s[IDX] = dest[IDX] & (yx ? row_lt : (col_eq & row_lt));
                if (ge == 0) begin : g_l0
                    assign to_l0[IDX] = dest[IDX] & col_eq & row_eq;
                    assign to_l1[IDX] = 1'b0;
                end else begin : g_l1
                    assign to_l0[IDX] = 1'b0;
                    assign to_l1[IDX] = dest[IDX] & col_eq & row_eq;
                end
            end
        end
    end
endmodule

// File: rtl/mc_route_unit.sv
module mc_route_unit
    import mc_pkg::*;
#(
    parameter int W  = 4,
    parameter int H  = 4,
    localparam int N  = W * H * ENDPOINTS_PER_NODE,
    localparam int XW = (W > 1) ? $clog2(W) : 1,
    localparam int YW = (H > 1) ? $clog2(H) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_inject,
    input  logic          in_lane,
    input  logic [N-1:0]  in_dest,
    input  logic [XW-1:0] here_x,
    input  logic [YW-1:0] here_y,
    output logic          out_valid,
    output logic          out_lane,
    output logic [N-1:0]  out_east,
    output logic [N-1:0]  out_west,
    output logic [N-1:0]  out_north,
    output logic [N-1:0]  out_south,
    output logic [N-1:0]  out_loc0,
    output logic [N-1:0]  out_loc1
);
    typedef struct packed {
        logic         vld;
        lane_e        lane;
        logic [N-1:0] e;
        logic [N-1:0] w;
        logic [N-1:0] n;
        logic [N-1:0] s;
        logic [N-1:0] l0;
        logic [N-1:0] l1;
    } route_t;

    route_t r_d, r_q;
    lane_e  pick_lane, use_lane;
    logic   inj_fire;
    logic [N-1:0] sp_e, sp_w, sp_n, sp_s, sp_l0, sp_l1;

    assign inj_fire = in_valid & in_inject;

    mc_lane_pick u_pick (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (inj_fire),
        .pick (pick_lane)
    );

    assign use_lane = in_inject ? pick_lane : lane_e'(in_lane);

    mc_port_split #(.W(W), .H(H)) u_split (
        .dest (in_dest),
        .lane (use_lane),
        .my_x (here_x),
        .my_y (here_y),
        .to_e (sp_e),
        .to_w (sp_w),
        .to_n (sp_n),
        .to_s (sp_s),
        .to_l0(sp_l0),
        .to_l1(sp_l1)
    );

    always_comb begin
        r_d = '0;
        if (in_valid) begin
            r_d.vld  = 1'b1;
            r_d.lane = use_lane;
            r_d.e    = sp_e;
            r_d.w    = sp_w;
            r_d.n    = sp_n;
            r_d.s    = sp_s;
            r_d.l0   = sp_l0;
            r_d.l1   = sp_l1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_valid = r_q.vld;
    assign out_lane  = r_q.lane;
    assign out_east  = r_q.e;
    assign out_west  = r_q.w;
    assign out_north = r_q.n;
    assign out_south = r_q.s;
    assign out_loc0  = r_q.l0;
    assign out_loc1  = r_q.l1;

    logic [N-1:0] all_out;
    assign all_out = out_east | out_west | out_north | out_south | out_loc0 | out_loc1;

    // R5
    disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_east) + $countones(out_west) + $countones(out_north)
                     + $countones(out_south) + $countones(out_loc0) + $countones(out_loc1))
                     == $countones(all_out));
    // R5
    union_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid) |-> all_out == $past(in_dest));
    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> (!out_valid && !out_lane && all_out == '0));
    // R6
    lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && !in_inject) |-> out_lane == $past(in_lane));
    // R4
    loc_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(out_loc0) <= 1 && $countones(out_loc1) <= 1);
endmodule

// File: tb/tb_mc_route_unit.sv
`timescale 1ns/1ps
module tb_mc_route_unit;
    localparam int W = 4;
    localparam int H = 4;
    localparam int N = W * H * 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0, in_inject = 1'b0, in_lane = 1'b0;
    logic [N-1:0] in_dest = '0;
    logic [1:0]   here_x = '0, here_y = '0;
    logic         out_valid, out_lane;
    logic [N-1:0] out_east, out_west, out_north, out_south, out_loc0, out_loc1;

    int errs = 0, checks = 0;
    bit done = 0;
    bit nxt_pick = 0;

    always #2 clk = ~clk;

    mc_route_unit #(.W(W), .H(H)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_inject(in_inject),
        .in_lane(in_lane), .in_dest(in_dest), .here_x(here_x), .here_y(here_y),
        .out_valid(out_valid), .out_lane(out_lane), .out_east(out_east),
        .out_west(out_west), .out_north(out_north), .out_south(out_south),
        .out_loc0(out_loc0), .out_loc1(out_loc1)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // port codes: 0 east, 1 west, 2 north, 3 south, 4 loc0, 5 loc1
    function automatic logic [N-1:0] ref_mask(input logic [N-1:0] d, input bit lane,
                                             input int mx, input int my, input int port);
        logic [N-1:0] m = '0;
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                for (int e = 0; e < 2; e++) begin
                    int idx = 2 * (y * W + x) + e;
                    int p;
                    if (x == mx && y == my)      p = 4 + e;
                    else if (!lane) p = (x > mx) ? 0 : (x < mx) ? 1 : (y > my) ? 2 : 3;
                    else            p = (y > my) ? 2 : (y < my) ? 3 : (x > mx) ? 0 : 1;
                    if (p == port) m[idx] = d[idx];
                end
            end
        end
        return m;
    endfunction

    task automatic step(input bit v, input bit inj, input bit ln, input logic [N-1:0] d,
                        input int mx, input int my, input string tag);
        bit el;
        in_valid = v; in_inject = inj; in_lane = ln; in_dest = d;
        here_x = 2'(mx); here_y = 2'(my);
        if (v && inj) begin el = nxt_pick; nxt_pick = ~nxt_pick; end
        else el = v ? ln : 1'b0;
        @(negedge clk);
        chk({tag, " R1 valid"}, N'(out_valid), N'(v));
        chk({tag, (v && inj) ? " R7 lane" : " R6 lane"}, N'(out_lane), N'(el));
        if (!v) begin
            chk({tag, " R1 idle masks"},
                out_east | out_west | out_north | out_south | out_loc0 | out_loc1, '0);
        end else begin
            chk({tag, el ? " R3 east" : " R2 east"},  out_east,  ref_mask(d, el, mx, my, 0));
            chk({tag, el ? " R3 west" : " R2 west"},  out_west,  ref_mask(d, el, mx, my, 1));
            chk({tag, el ? " R3 north" : " R2 north"}, out_north, ref_mask(d, el, mx, my, 2));
            chk({tag, el ? " R3 south" : " R2 south"}, out_south, ref_mask(d, el, mx, my, 3));
            chk({tag, " R4 loc0"}, out_loc0, ref_mask(d, el, mx, my, 4));
            chk({tag, " R4 loc1"}, out_loc1, ref_mask(d, el, mx, my, 5));
            chk({tag, " R5 union"},
                out_east | out_west | out_north | out_south | out_loc0 | out_loc1, d);
        end
    endtask

    initial begin
        logic [N-1:0] rd;
        void'($urandom(32'd20240613));
        repeat (3) @(negedge clk);
        chk("R8 reset valid", N'(out_valid), '0);
        chk("R8 reset masks", out_east | out_west | out_north | out_south | out_loc0 | out_loc1, '0);
        rst_n = 1'b1;
        // R4 own endpoints split across the two local ports
        step(1, 0, 0, N'(1) << 2 * (1 * W + 2), 2, 1, "own e0");
        step(1, 0, 1, N'(1) << (2 * (1 * W + 2) + 1), 2, 1, "own e1");
        // R1 invalid input with a full mask is ignored
        step(0, 0, 1, '1, 1, 1, "idle");
        // all-ones at corners and interior, both lanes (R2, R3)
        step(1, 0, 0, '1, 0, 0, "corner xy");
        step(1, 0, 1, '1, 3, 3, "corner yx");
        step(1, 0, 0, '1, 1, 2, "inner xy");
        step(1, 0, 1, '1, 1, 2, "inner yx");
        step(1, 0, 0, '0, 2, 2, "empty");
        // R7 injections with in_lane opposing the expected pick, back to back
        for (int i = 0; i < 4; i++) step(1, 1, ~nxt_pick, '1, 2, 1, "inject");
        step(1, 0, 1, 32'h00F0_0F0F, 3, 0, "transit");
        step(0, 1, 0, '1, 3, 0, "idle inj");
        step(1, 1, 1, 32'h8001_4002, 0, 3, "inject after idle");
        // random mix
        for (int i = 0; i < 400; i++) begin
            int k = $urandom_range(0, 9);
            rd = $urandom();
            if (k == 0) rd = '1;
            step(k != 9, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, rd,
                 $urandom_range(0, W - 1), $urandom_range(0, H - 1), "rand");
        end
        // R8 reset restores lane 0 pick
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        chk("R8 reset mid-run", N'(out_valid), '0);
        rst_n = 1'b1; nxt_pick = 0;
        step(1, 1, 1, '1, 1, 1, "R8 first pick");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule